// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers up to eight interrupt request lines and presents them to a processor as one interrupt output. Each line is assigned a fixed priority, and line 0 ranks highest. When the processor pulses acknowledge, the block returns an 8-bit vector for the winning line. Software reaches the block over a byte bus with two addresses: a command port and a data port. Each bus access is a strobe that lasts one cycle.

The block will not raise an interrupt until it has been set up. Setup starts with a command byte that has bit 4 set, followed by three data-port bytes: the vector base, a cascade byte that is accepted and discarded, and a mode byte. Once running, the block accepts the following:

- data-port writes that set the mask;
- end-of-interrupt commands, both non-specific and specific to a line;
- a command that selects whether command-port reads return pending requests or in-service lines.

Each line can be rising-edge or level sensitive, under a static select input. An acknowledge that finds nothing eligible returns the vector of the lowest-priority line and marks nothing in service.

Top module: `prio_intc`

## Requirements
- R1: After reset, and from the start of setup until the third setup data byte has been written, `irq_out` stays low whatever the request lines do.
- R2: A granted acknowledge for line n returns vector base+n (8-bit sum), where base is the first setup data byte.
- R3: Line 0 has the highest priority and line 7 the lowest. One cycle after the state changes, `irq_out` reflects whether some unmasked pending line ranks above every in-service line, and an acknowledge grants the highest-ranked such line.
- R4: While running, a data-port write loads the mask, where bit n = 1 blocks line n from raising `irq_out` or being granted. A data-port read returns the mask.
- R5: A granted acknowledge sets the winner's in-service bit, unless auto-EOI is on. For an edge-sensitive winner it also clears the pending bit.
- R6: Command byte 0x20 clears the highest-priority in-service bit.
- R7: Command byte 0x60+n (n = 0..7) clears in-service bit n, whatever its priority.
- R8: After command 0x0B, command-port reads return the in-service bits. After command 0x0A they return the pending bits. Pending is the selection after reset and after setup starts.
- R9: Bit 1 of the third setup data byte turns on auto-EOI. With it on, a granted acknowledge leaves the in-service bits unchanged.
- R10: An acknowledge with no eligible line returns base+7 and leaves the in-service bits unchanged, even when line 7 is masked.
- R11: `irq_level` bit n = 1 makes pending bit n follow the line's level. When bit n = 0, a rising edge latches the pending bit, and it stays set until that line is granted.
- R12: Reset and every setup-start command clear the pending bits, the in-service bits, the mask and the edge history, and select pending-bit readback.
- R13: `irq_vec` and `bus_rdata` are registered. They change only in the cycle after an acknowledge or a read strobe, and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | 1 | 0 = command port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| irq_in | input | N_IN | Request lines |
| irq_level | input | N_IN | Per-line trigger select, 1 = level, 0 = rising edge |
| irq_ack | input | 1 | Acknowledge pulse |
| irq_out | output | 1 | Interrupt to the processor |
| irq_vec | output | 8 | Vector, valid the cycle after `irq_ack` |

## Verification
The bench builds the block with its default of eight lines. At that width the spurious vector is base+7, and the specific-EOI field covers every line, so both boundaries can be reached. The full eight-bit priority chain can also be probed, from line 0 down to line 7. Two setups are run with different vector bases, which shows that the base, the mode byte and the clearing done at setup start all take effect on a second pass.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

  localparam int BW = 8;

  typedef enum logic [2:0] {
    CFG_IDLE,
    CFG_BASE,
    CFG_CASC,
    CFG_MODE,
    CFG_RUN
  } cfg_step_t;

  localparam int          INIT_BIT  = 4;
  localparam int          AEOI_BIT  = 1;
  localparam logic [7:0]  CMD_NSEOI = 8'h20;
  localparam logic [4:0]  SEOI_TAG  = 5'b01100;

endpackage

// File: rtl/prio_intc_capture.sv
module prio_intc_capture #(
  parameter int N_IN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [N_IN-1:0] lines,
  input  logic [N_IN-1:0] level_sel,
  input  logic [N_IN-1:0] ack_clr,
  output logic [N_IN-1:0] irr
);

  logic [N_IN-1:0] prev_q;
  logic [N_IN-1:0] irr_q;
  logic [N_IN-1:0] irr_d;

  genvar gi;
  generate
    for (gi = 0; gi < N_IN; gi++) begin : g_line
      assign irr_d[gi] = level_sel[gi] ? lines[gi]
                       : ((irr_q[gi] & ~ack_clr[gi]) | (lines[gi] & ~prev_q[gi]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= lines;
      irr_q  <= irr_d;
    end
  end

  assign irr = irr_q;

endmodule

// File: rtl/prio_intc_resolve.sv
module prio_intc_resolve #(
  parameter int N_IN = 8,
  parameter int IW   = $clog2(N_IN)
) (
  input  logic [N_IN-1:0] irr,
  input  logic [N_IN-1:0] imr,
  input  logic [N_IN-1:0] isr,
  output logic            win_vld,
  output logic [N_IN-1:0] win_oh,
  output logic [IW-1:0]   win_idx,
  output logic [N_IN-1:0] isr_top_oh
);

  localparam logic [N_IN-1:0] ONE = {{(N_IN-1){1'b0}}, 1'b1};

  logic [N_IN-1:0] req;
  logic [N_IN-1:0] req_oh;
  logic [N_IN-1:0] isr_oh;

  assign req    = irr & ~imr;
  assign req_oh = req & (~req + ONE);
  assign isr_oh = isr & (~isr + ONE);

  assign win_vld    = (req != '0) && ((isr == '0) || (req_oh < isr_oh));
  assign win_oh     = req_oh;
  assign isr_top_oh = isr_oh;

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (req_oh[i]) win_idx = win_idx | IW'(i);
    end
  end

endmodule

// File: rtl/prio_intc_ctl.sv
module prio_intc_ctl
  import prio_intc_pkg::*;
#(
  parameter int N_IN = 8,
  parameter int IW   = $clog2(N_IN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic            addr,
  input  logic [BW-1:0]   wdata,
  input  logic            ack,
  input  logic [N_IN-1:0] irr,
  input  logic            win_vld,
  input  logic [N_IN-1:0] win_oh,
  input  logic [IW-1:0]   win_idx,
  input  logic [N_IN-1:0] isr_top_oh,
  output logic            init_clr,
  output logic [N_IN-1:0] ack_clr,
  output logic [N_IN-1:0] isr,
  output logic [N_IN-1:0] imr,
  output logic [BW-1:0]   rdata,
  output logic [BW-1:0]   vec,
  output logic            int_out
);

  cfg_step_t       step_q;
  logic [BW-1:0]   base_q;
  logic            aeoi_q;
  logic            sel_isr_q;
  logic [N_IN-1:0] isr_q;
  logic [N_IN-1:0] imr_q;
  logic [BW-1:0]   rdata_q;
  logic [BW-1:0]   vec_q;
  logic            int_q;

  logic            running;
  logic            cmd_wr;
  logic            dat_wr;
  logic            init_go;
  logic            nseoi;
  logic            seoi;
  logic            rdsel_cmd;
  logic            grant;
  logic [N_IN-1:0] seoi_oh;
  logic [N_IN-1:0] eoi_clr;
  logic [N_IN-1:0] isr_set;
  logic [BW-1:0]   sel_rd;

  assign running   = (step_q == CFG_RUN);
  assign cmd_wr    = wr_en & ~addr;
  assign dat_wr    = wr_en & addr;
  assign init_go   = cmd_wr & wdata[INIT_BIT];
  assign nseoi     = cmd_wr & (wdata == CMD_NSEOI);
  assign seoi      = cmd_wr & (wdata[7:3] == SEOI_TAG);
  assign rdsel_cmd = cmd_wr & ~wdata[INIT_BIT] & (wdata[7:5] == 3'b000) & wdata[3] & wdata[1];
  assign grant     = ack & win_vld & running;

  genvar gi;
  generate
    for (gi = 0; gi < N_IN; gi++) begin : g_seoi
      assign seoi_oh[gi] = (wdata[2:0] == 3'(gi));
    end
  endgenerate

  assign eoi_clr  = (nseoi ? isr_top_oh : '0) | (seoi ? seoi_oh : '0);
  assign isr_set  = (grant && !aeoi_q) ? win_oh : '0;
  assign ack_clr  = grant ? win_oh : '0;
  assign init_clr = init_go;

  always_comb begin
    if (addr)           sel_rd = BW'(imr_q);
    else if (sel_isr_q) sel_rd = BW'(isr_q);
    else                sel_rd = BW'(irr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q    <= CFG_IDLE;
      base_q    <= '0;
      aeoi_q    <= 1'b0;
      sel_isr_q <= 1'b0;
      isr_q     <= '0;
      imr_q     <= '0;
    end else if (init_go) begin
      step_q    <= CFG_BASE;
      sel_isr_q <= 1'b0;
      isr_q     <= '0;
      imr_q     <= '0;
    end else begin
      isr_q <= (isr_q & ~eoi_clr) | isr_set;
      if (rdsel_cmd) sel_isr_q <= wdata[0];
      if (dat_wr) begin
        case (step_q)
          CFG_BASE: begin
            base_q <= wdata;
            step_q <= CFG_CASC;
          end
          CFG_CASC: step_q <= CFG_MODE;
          CFG_MODE: begin
            aeoi_q <= wdata[AEOI_BIT];
            step_q <= CFG_RUN;
          end
          CFG_RUN:  imr_q <= wdata[N_IN-1:0];
          default:  step_q <= step_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      vec_q   <= '0;
      int_q   <= 1'b0;
    end else begin
      int_q <= running & win_vld;
      if (rd_en) rdata_q <= sel_rd;
      if (ack)   vec_q   <= grant ? (base_q + BW'(win_idx)) : (base_q + BW'(N_IN - 1));
    end
  end

  assign isr     = isr_q;
  assign imr     = imr_q;
  assign rdata   = rdata_q;
  assign vec     = vec_q;
  assign int_out = int_q;

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int N_IN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic            bus_addr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic [N_IN-1:0] irq_in,
  input  logic [N_IN-1:0] irq_level,
  input  logic            irq_ack,
  output logic            irq_out,
  output logic [7:0]      irq_vec
);

  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1;

  logic [N_IN-1:0] irr_w;
  logic [N_IN-1:0] isr_w;
  logic [N_IN-1:0] imr_w;
  logic [N_IN-1:0] win_oh_w;
  logic [N_IN-1:0] isr_top_w;
  logic [N_IN-1:0] ack_clr_w;
  logic [IW-1:0]   win_idx_w;
  logic            win_vld_w;
  logic            init_clr_w;

  prio_intc_capture #(.N_IN(N_IN)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .clr       (init_clr_w),
    .lines     (irq_in),
    .level_sel (irq_level),
    .ack_clr   (ack_clr_w),
    .irr       (irr_w)
  );

  prio_intc_resolve #(.N_IN(N_IN), .IW(IW)) u_res (
    .irr        (irr_w),
    .imr        (imr_w),
    .isr        (isr_w),
    .win_vld    (win_vld_w),
    .win_oh     (win_oh_w),
    .win_idx    (win_idx_w),
    .isr_top_oh (isr_top_w)
  );

  prio_intc_ctl #(.N_IN(N_IN), .IW(IW)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (bus_wr),
    .rd_en      (bus_rd),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .ack        (irq_ack),
    .irr        (irr_w),
    .win_vld    (win_vld_w),
    .win_oh     (win_oh_w),
    .win_idx    (win_idx_w),
    .isr_top_oh (isr_top_w),
    .init_clr   (init_clr_w),
    .ack_clr    (ack_clr_w),
    .isr        (isr_w),
    .imr        (imr_w),
    .rdata      (bus_rdata),
    .vec        (irq_vec),
    .int_out    (irq_out)
  );

endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int N_IN = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic            bus_addr,
  input logic [7:0]      bus_wdata,
  input logic [7:0]      bus_rdata,
  input logic            irq_ack,
  input logic            irq_out,
  input logic [7:0]      irq_vec,
  input logic [N_IN-1:0] irr,
  input logic [N_IN-1:0] isr,
  input logic [N_IN-1:0] imr
);

  logic [N_IN-1:0] seoi_oh;
  always_comb begin
    for (int i = 0; i < N_IN; i++) seoi_oh[i] = (bus_wdata[2:0] == 3'(i));
  end

  p_quiet_after_reset_r1: assert property (@(posedge clk) rst |=> !irq_out);

  p_init_clears_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_addr && bus_wdata[4]) |=> (isr == '0 && imr == '0 && irr == '0));

  p_one_grant_r5: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> ($countones(isr) <= $countones($past(isr)) + 1));

  p_int_eligible_r3: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> ($past(irr & ~imr) != '0));

  p_seoi_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_addr && bus_wdata[7:3] == 5'b01100 && !irq_ack)
      |=> ((isr & $past(seoi_oh)) == '0));

  p_vec_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !irq_ack |=> $stable(irq_vec));

  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind prio_intc prio_intc_chk #(.N_IN(N_IN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_ack   (irq_ack),
  .irq_out   (irq_out),
  .irq_vec   (irq_vec),
  .irr       (irr_w),
  .isr       (isr_w),
  .imr       (imr_w)
);

// File: tb/sim_prio_intc.sv
`timescale 1ns/1ps
module sim_prio_intc;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] irq_in = 8'h00;
  logic [7:0] irq_level = 8'h00;
  logic       irq_ack = 1'b0;
  logic       irq_out;
  logic [7:0] irq_vec;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  prio_intc #(.N_IN(8)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .irq_level(irq_level), .irq_ack(irq_ack), .irq_out(irq_out), .irq_vec(irq_vec)
  );

  // behavioural reference model
  bit [7:0] m_irr, m_isr, m_imr, m_prev, m_base, m_vec, m_rd;
  bit       m_aeoi, m_sel, m_int;
  int       m_step;

  always @(posedge clk) begin : mdl
    bit [7:0] o_irr, o_isr, o_imr, o_prev, o_base;
    bit       o_aeoi, o_sel, run, elig, grant;
    int       o_step, w, t;
    if (rst) begin
      m_irr = 0; m_isr = 0; m_imr = 0; m_prev = 0; m_base = 0; m_vec = 0; m_rd = 0;
      m_aeoi = 0; m_sel = 0; m_int = 0; m_step = 0;
    end else begin
      o_irr = m_irr; o_isr = m_isr; o_imr = m_imr; o_prev = m_prev; o_base = m_base;
      o_aeoi = m_aeoi; o_sel = m_sel; o_step = m_step;
      run = (o_step == 4);
      w = 8; t = 8;
      for (int i = 7; i >= 0; i--) begin
        if (o_irr[i] && !o_imr[i]) w = i;
        if (o_isr[i]) t = i;
      end
      elig  = (w < 8) && (w < t);
      grant = irq_ack && elig && run;
      m_int = run && elig;
      if (irq_ack) m_vec = grant ? o_base + 8'(w) : o_base + 8'd7;
      if (bus_rd) m_rd = bus_addr ? o_imr : (o_sel ? o_isr : o_irr);
      for (int i = 0; i < 8; i++) begin
        if (irq_level[i]) m_irr[i] = irq_in[i];
        else m_irr[i] = (o_irr[i] && !(grant && w == i)) || (irq_in[i] && !o_prev[i]);
      end
      m_prev = irq_in;
      if (bus_wr && !bus_addr && bus_wdata[4]) begin
        m_step = 1; m_irr = 0; m_prev = 0; m_isr = 0; m_imr = 0; m_sel = 0;
      end else begin
        if (bus_wr && !bus_addr) begin
          if (bus_wdata == 8'h20) begin
            if (t < 8) m_isr[t] = 1'b0;
          end else if (bus_wdata[7:3] == 5'b01100) begin
            m_isr[bus_wdata[2:0]] = 1'b0;
          end else if (bus_wdata[7:5] == 3'b000 && bus_wdata[3] && bus_wdata[1]) begin
            m_sel = bus_wdata[0];
          end
        end
        if (grant && !o_aeoi) m_isr[w] = 1'b1;
        if (bus_wr && bus_addr) begin
          case (o_step)
            1: begin m_base = bus_wdata; m_step = 2; end
            2: m_step = 3;
            3: begin m_aeoi = bus_wdata[1]; m_step = 4; end
            4: m_imr = bus_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      nchk++;
      if (irq_out !== m_int) begin
        nfail++;
        $display("FAIL R3 irq_out actual=%0b expected=%0b at %0t", irq_out, m_int, $time);
      end
      if (irq_vec !== m_vec) begin
        nfail++;
        $display("FAIL R2 irq_vec actual=%h expected=%h at %0t", irq_vec, m_vec, $time);
      end
      if (bus_rdata !== m_rd) begin
        nfail++;
        $display("FAIL R8 bus_rdata actual=%h expected=%h at %0t", bus_rdata, m_rd, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ackp();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #800000;
    nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R12 reset irq_out", {7'd0, irq_out}, 8'h00);
    chk("R12 reset irq_vec", irq_vec, 8'h00);
    chk("R12 reset rdata", bus_rdata, 8'h00);

    // first setup, base 0x20, normal EOI
    wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h01);
    rd(1, r); chk("R12 mask clear after setup", r, 8'h00);

    irq_in[3] = 1'b1; idle(2);
    chk("R3 int for line 3", {7'd0, irq_out}, 8'h01);
    ackp(); chk("R2 vector line 3", irq_vec, 8'h23);
    wr(0, 8'h0B); rd(0, r); chk("R5 isr after ack", r, 8'h08);
    wr(0, 8'h0A); rd(0, r); chk("R11 edge bit cleared by ack", r, 8'h00);
    chk("R8 irr readback select", r, 8'h00);

    irq_in[1] = 1'b1; idle(2);
    chk("R3 higher line preempts", {7'd0, irq_out}, 8'h01);
    ackp(); chk("R2 vector line 1", irq_vec, 8'h21);
    wr(0, 8'h0B); rd(0, r); chk("R5 nested isr", r, 8'h0A);
    wr(0, 8'h20); rd(0, r); chk("R6 nonspecific eoi", r, 8'h08);
    wr(0, 8'h63); rd(0, r); chk("R7 specific eoi", r, 8'h00);

    wr(1, 8'h10); irq_in[4] = 1'b1; idle(3);
    chk("R4 masked line quiet", {7'd0, irq_out}, 8'h00);
    rd(1, r); chk("R4 mask readback", r, 8'h10);
    wr(1, 8'h00); idle(2);
    chk("R4 unmasked line raises", {7'd0, irq_out}, 8'h01);
    ackp(); chk("R2 vector line 4", irq_vec, 8'h24);
    wr(0, 8'h20);

    wr(1, 8'h80); irq_level = 8'h20; irq_in[5] = 1'b1; idle(2);
    wr(0, 8'h0A); rd(0, r); chk("R11 level line pending", r, 8'h20);
    irq_in[5] = 1'b0; idle(1);
    ackp(); chk("R10 spurious vector", irq_vec, 8'h27);
    wr(0, 8'h0B); rd(0, r); chk("R10 isr untouched", r, 8'h00);

    irq_level = 8'h00; irq_in[0] = 1'b1; idle(2);
    ackp(); chk("R2 vector line 0", irq_vec, 8'h20);
    irq_in = 8'h00; idle(2);

    // second setup, base 0x40, auto-EOI
    wr(0, 8'h11);
    rd(1, r); chk("R12 setup clears mask", r, 8'h80 & 8'h00);
    wr(0, 8'h0B); rd(0, r); chk("R12 setup clears isr", r, 8'h00);
    wr(1, 8'h40); wr(1, 8'h00);
    irq_in[6] = 1'b1; idle(3);
    chk("R1 quiet until setup done", {7'd0, irq_out}, 8'h00);
    wr(1, 8'h03); idle(1);
    chk("R1 raises once running", {7'd0, irq_out}, 8'h01);
    ackp(); chk("R2 vector new base", irq_vec, 8'h46);
    rd(0, r); chk("R9 auto eoi isr empty", r, 8'h00);

    irq_in[2] = 1'b1; irq_in[5] = 1'b1; idle(2);
    ackp(); chk("R3 line 2 first", irq_vec, 8'h42);
    ackp(); chk("R3 line 5 next", irq_vec, 8'h45);
    idle(3); chk("R13 vector held", irq_vec, 8'h45);

    idle(2);
    summary();
  end

endmodule